// File: doc/BRIEF.md
# Transport-Triggered Move Core

This block is a small processor whose only instruction is a data transfer between numbered transport ports. Each fetched bundle is 64 bits wide and holds four 16-bit move slots. All four slots issue in the same cycle. A slot names a source and a destination, and it carries a 3-bit guard that decides whether the move takes effect. There is no opcode. Computation happens as a side effect of writes. Writing an operand port latches one input of a function unit. Writing that unit's trigger port starts the operation, and the add result then becomes readable on a source port. The program counter is itself a destination port, so a jump is an ordinary guarded move.

The core has an 11-entry register file, one adder and one compare unit. The compare unit drives three boolean flags, and the guards test those flags. The testbench preloads the synchronous instruction memory through a load port while reset is held. A debug port returns the contents of any register, so a program's effects can be observed after it stops in a self-jump.

Top module: `ttaMoveCore`

## Requirements
- R1: Slot k of a bundle occupies bits [16k+15:16k]. Within a slot, bits [15:13] are the guard, [12:7] the source ID, bit 6 the immediate flag and [5:0] the destination ID. When the immediate flag is 1, the 6-bit source field is sign-extended to 16 bits and used as the value.
- R2: Guard 0 always executes the move. Guard 1 never executes it, and such a move changes no register, port or PC.
- R3: Guards 2/3 select flag f0 or its inverse, 4/5 select f1 or its inverse, and 6/7 select f2 or its inverse. The compare operand port is destination 18. A write to destination 19 sets f0 = (operand == value), destination 20 sets f1 = (operand < value, signed), and destination 21 sets f2 = (operand < value, unsigned). Guards always use the flag values from before the bundle issues. flagsOut bit i is fi.
- R4: Destination 16 is the adder operand and destination 17 is the adder trigger. A trigger sets the result to operand + value. The result is readable as source 16 from the next bundle onward. An operand written in the same bundle as the trigger is the one used.
- R5: Source 0 (r0) always reads zero and writes to destination 0 are ignored. IDs 1 to 10 are general registers r1 to r10, readable and writable.
- R6: Destination 24 is the PC. A taken PC move makes the written value the next fetch address, with no bundle in between. Source 17 reads the address of the current bundle plus one.
- R7: When several executed moves in one bundle target the same destination, the highest-numbered slot wins. This includes the PC.
- R8: Every source read in a bundle sees the state from before that bundle, so two moves in one bundle can swap two registers.
- R9: While reset is asserted, the PC, all registers and all flags are zero. The first bundle fetched after reset is the one at address 0.
- R10: Without a taken PC move, the next bundle fetched is at PC + 1, one bundle per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadWe | input | 1 | Instruction memory write strobe |
| loadAddr | input | 6 | Instruction memory write address |
| loadData | input | 64 | Bundle to write |
| dbgSel | input | 4 | Register number to observe |
| dbgData | output | 16 | Contents of the selected register (zero for r0 or out of range) |
| pcOut | output | 6 | Address of the bundle currently executing |
| flagsOut | output | 3 | Compare flags f2..f0 |

## Verification
The bench targets the moments where state is read and written in the same bundle. One case is a register swap, which a design forwarding new values to readers would turn into a copy. Another is a guard that reads a flag while a compare in the same bundle overwrites it, where a forwarding design would skip the move. A third is an adder trigger whose operand arrives in the same bundle, where a design that used the stale operand would produce a wrong sum. The bench also covers two slots writing one register and two slots writing the PC. A reversed priority would leave the lower slot's value or execute the skipped bundles. Never-guards, writes to r0, negative immediates and a compare-controlled loop round out the cases. A wrong link address or a broken loop exit shows up in the final register values and the final PC.

// File: rtl/ttaPkg.sv
package ttaPkg;
  localparam int SLOTS      = 4;
  localparam int MOVE_W     = 16;
  localparam int BUNDLE_W   = SLOTS * MOVE_W;
  localparam int DATA_W     = 16;
  localparam int NUM_REGS   = 11;
  localparam int REG_W      = $clog2(NUM_REGS);
  localparam int PC_W       = 6;
  localparam int IMEM_DEPTH = 1 << PC_W;
  localparam int ID_W       = 6;
  localparam int GUARD_W    = 3;
  localparam int NUM_FLAGS  = 3;

  // Field positions inside one move slot
  localparam int DST_LSB   = 0;
  localparam int IMM_BIT   = DST_LSB + ID_W;
  localparam int SRC_LSB   = IMM_BIT + 1;
  localparam int GUARD_LSB = SRC_LSB + ID_W;

  // Source identifiers beyond the register file
  localparam logic [ID_W-1:0] SRC_ADD_RES = 6'd16;
  localparam logic [ID_W-1:0] SRC_LINK    = 6'd17;

  // Destination identifiers beyond the register file
  localparam logic [ID_W-1:0] DST_ADD_OPD = 6'd16;
  localparam logic [ID_W-1:0] DST_ADD_TRG = 6'd17;
  localparam logic [ID_W-1:0] DST_CMP_OPD = 6'd18;
  localparam logic [ID_W-1:0] DST_CMP_EQ  = 6'd19;
  localparam logic [ID_W-1:0] DST_CMP_LT  = 6'd20;
  localparam logic [ID_W-1:0] DST_CMP_LTU = 6'd21;
  localparam logic [ID_W-1:0] DST_PC      = 6'd24;

  // Control-to-datapath strobe for one slot
  typedef struct packed {
    logic            act;
    logic            imm;
    logic [ID_W-1:0] src;
    logic [ID_W-1:0] dst;
  } moveStrobe_t;
endpackage

// File: rtl/ttaImem.sv
module ttaImem
  import ttaPkg::*;
(
  input  logic                clk,
  input  logic                we,
  input  logic [PC_W-1:0]     wAddr,
  input  logic [BUNDLE_W-1:0] wData,
  input  logic [PC_W-1:0]     rAddr,
  output logic [BUNDLE_W-1:0] rData
);
  logic [BUNDLE_W-1:0] mem [IMEM_DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
    rData <= mem[rAddr];
  end
endmodule

// File: rtl/ttaControl.sv
module ttaControl
  import ttaPkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [BUNDLE_W-1:0]             bundle,
  input  logic [NUM_FLAGS-1:0]            flags,
  input  logic [SLOTS-1:0][DATA_W-1:0]    busData,
  output moveStrobe_t [SLOTS-1:0]         strb,
  output logic [PC_W-1:0]                 fetchAddr,
  output logic [PC_W-1:0]                 pc,
  output logic [PC_W-1:0]                 linkPc
);
  logic            valid;
  logic            pcTake;
  logic [PC_W-1:0] pcTarget;

  function automatic logic guardPass(input logic [GUARD_W-1:0] g,
                                     input logic [NUM_FLAGS-1:0] f);
    case (g)
      3'd0:    return 1'b1;
      3'd1:    return 1'b0;
      3'd2:    return f[0];
      3'd3:    return ~f[0];
      3'd4:    return f[1];
      3'd5:    return ~f[1];
      3'd6:    return f[2];
      default: return ~f[2];
    endcase
  endfunction

  // Slot decode and guard evaluation against pre-bundle flags
  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    logic [MOVE_W-1:0] mv;
    assign mv = bundle[s*MOVE_W +: MOVE_W];
    assign strb[s].act = valid && guardPass(mv[GUARD_LSB +: GUARD_W], flags);
    assign strb[s].imm = mv[IMM_BIT];
    assign strb[s].src = mv[SRC_LSB +: ID_W];
    assign strb[s].dst = mv[DST_LSB +: ID_W];
  end

  // PC move resolution: the last executed slot targeting the PC wins
  always_comb begin
    pcTake   = 1'b0;
    pcTarget = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (strb[s].act && strb[s].dst == DST_PC) begin
        pcTake   = 1'b1;
        pcTarget = busData[s][PC_W-1:0];
      end
    end
  end

  assign linkPc    = pc + 1'b1;
  assign fetchAddr = !valid ? '0 : (pcTake ? pcTarget : linkPc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid <= 1'b0;
      pc    <= '0;
    end else begin
      valid <= 1'b1;
      pc    <= fetchAddr;
    end
  end

  AST_FETCH_START: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> (pc == '0)); // R9
  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !pcTake) |=> (pc == PC_W'($past(pc) + 1'b1))); // R10
  AST_PC_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    (valid && pcTake) |=> (pc == $past(pcTarget))); // R6
endmodule

// File: rtl/ttaDatapath.sv
module ttaDatapath
  import ttaPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  moveStrobe_t [SLOTS-1:0]      strb,
  input  logic [PC_W-1:0]              linkPc,
  input  logic [REG_W-1:0]             dbgSel,
  output logic [SLOTS-1:0][DATA_W-1:0] busData,
  output logic [NUM_FLAGS-1:0]         flags,
  output logic [DATA_W-1:0]            dbgData
);
  logic [DATA_W-1:0] rf [NUM_REGS];
  logic [DATA_W-1:0] addOpd, addRes, cmpOpd;

  logic [NUM_REGS-1:0] regWe;
  logic [DATA_W-1:0]   regWd [NUM_REGS];
  logic                addOpdWe, addTrgWe, cmpOpdWe;
  logic [DATA_W-1:0]   addOpdWd, addTrgWd, cmpOpdWd;
  logic [NUM_FLAGS-1:0] cmpTrgWe;
  logic [DATA_W-1:0]   cmpTrgWd [NUM_FLAGS];
  logic [DATA_W-1:0]   addOpdEff, cmpOpdEff;

  // Source side: every read sees pre-bundle state
  for (genvar s = 0; s < SLOTS; s++) begin : gBus
    always_comb begin
      if (strb[s].imm) begin
        busData[s] = {{(DATA_W-ID_W){strb[s].src[ID_W-1]}}, strb[s].src};
      end else if (strb[s].src == '0) begin
        busData[s] = '0;
      end else if (int'(strb[s].src) < NUM_REGS) begin
        busData[s] = rf[strb[s].src[REG_W-1:0]];
      end else if (strb[s].src == SRC_ADD_RES) begin
        busData[s] = addRes;
      end else if (strb[s].src == SRC_LINK) begin
        busData[s] = DATA_W'(linkPc);
      end else begin
        busData[s] = '0;
      end
    end
  end

  // Destination side: later slots override earlier ones
  always_comb begin
    regWe    = '0;
    addOpdWe = 1'b0; addOpdWd = '0;
    addTrgWe = 1'b0; addTrgWd = '0;
    cmpOpdWe = 1'b0; cmpOpdWd = '0;
    cmpTrgWe = '0;
    for (int i = 0; i < NUM_REGS; i++) regWd[i] = '0;
    for (int f = 0; f < NUM_FLAGS; f++) cmpTrgWd[f] = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (strb[s].act) begin
        if (strb[s].dst != '0 && int'(strb[s].dst) < NUM_REGS) begin
          regWe[strb[s].dst[REG_W-1:0]] = 1'b1;
          regWd[strb[s].dst[REG_W-1:0]] = busData[s];
        end
        case (strb[s].dst)
          DST_ADD_OPD: begin addOpdWe = 1'b1; addOpdWd = busData[s]; end
          DST_ADD_TRG: begin addTrgWe = 1'b1; addTrgWd = busData[s]; end
          DST_CMP_OPD: begin cmpOpdWe = 1'b1; cmpOpdWd = busData[s]; end
          DST_CMP_EQ:  begin cmpTrgWe[0] = 1'b1; cmpTrgWd[0] = busData[s]; end
          DST_CMP_LT:  begin cmpTrgWe[1] = 1'b1; cmpTrgWd[1] = busData[s]; end
          DST_CMP_LTU: begin cmpTrgWe[2] = 1'b1; cmpTrgWd[2] = busData[s]; end
          default: ;
        endcase
      end
    end
  end

  // Operands written in the same bundle as a trigger take part in it
  assign addOpdEff = addOpdWe ? addOpdWd : addOpd;
  assign cmpOpdEff = cmpOpdWe ? cmpOpdWd : cmpOpd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) rf[i] <= '0;
    end else begin
      for (int i = 1; i < NUM_REGS; i++) if (regWe[i]) rf[i] <= regWd[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addOpd <= '0;
      addRes <= '0;
      cmpOpd <= '0;
      flags  <= '0;
    end else begin
      if (addOpdWe) addOpd <= addOpdWd;
      if (addTrgWe) addRes <= addOpdEff + addTrgWd;
      if (cmpOpdWe) cmpOpd <= cmpOpdWd;
      if (cmpTrgWe[0]) flags[0] <= (cmpOpdEff == cmpTrgWd[0]);
      if (cmpTrgWe[1]) flags[1] <= ($signed(cmpOpdEff) < $signed(cmpTrgWd[1]));
      if (cmpTrgWe[2]) flags[2] <= (cmpOpdEff < cmpTrgWd[2]);
    end
  end

  assign dbgData = (int'(dbgSel) < NUM_REGS) ? rf[dbgSel] : '0;

  for (genvar s = 0; s < SLOTS; s++) begin : gChk
    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (strb[s].act && !strb[s].imm && strb[s].src == '0) |-> (busData[s] == '0)); // R5
  end
  AST_ADD_RES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !addTrgWe |=> $stable(addRes)); // R4
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmpTrgWe == '0) |=> $stable(flags)); // R3
endmodule

// File: rtl/ttaMoveCore.sv
module ttaMoveCore
  import ttaPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadWe,
  input  logic [PC_W-1:0]      loadAddr,
  input  logic [BUNDLE_W-1:0]  loadData,
  input  logic [REG_W-1:0]     dbgSel,
  output logic [DATA_W-1:0]    dbgData,
  output logic [PC_W-1:0]      pcOut,
  output logic [NUM_FLAGS-1:0] flagsOut
);
  logic [BUNDLE_W-1:0]          bundle;
  logic [PC_W-1:0]              fetchAddr, linkPc;
  logic [NUM_FLAGS-1:0]         flags;
  logic [SLOTS-1:0][DATA_W-1:0] busData;
  moveStrobe_t [SLOTS-1:0]      strb;

  ttaImem imem_i (
    .clk(clk), .we(loadWe), .wAddr(loadAddr), .wData(loadData),
    .rAddr(fetchAddr), .rData(bundle)
  );

  ttaControl ctrl_i (
    .clk(clk), .rstN(rstN), .bundle(bundle), .flags(flags),
    .busData(busData), .strb(strb), .fetchAddr(fetchAddr),
    .pc(pcOut), .linkPc(linkPc)
  );

  ttaDatapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .linkPc(linkPc),
    .dbgSel(dbgSel), .busData(busData), .flags(flags), .dbgData(dbgData)
  );

  assign flagsOut = flags;
endmodule

// File: tb/ttaMoveCore_tb_top.sv
`timescale 1ns/1ps
module ttaMoveCore_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadWe = 1'b0;
  logic [5:0]  loadAddr = '0;
  logic [63:0] loadData = '0;
  logic [3:0]  dbgSel = '0;
  logic [15:0] dbgData;
  logic [5:0]  pcOut;
  logic [2:0]  flagsOut;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [63:0] prog [16];

  always #5 clk = ~clk;

  ttaMoveCore dut_i (
    .clk(clk), .rstN(rstN), .loadWe(loadWe), .loadAddr(loadAddr),
    .loadData(loadData), .dbgSel(dbgSel), .dbgData(dbgData),
    .pcOut(pcOut), .flagsOut(flagsOut)
  );

  // Move encoding per R1: guard, source, immediate flag, destination
  function automatic logic [15:0] mv(input int g, input int src, input bit imm, input int dst);
    logic [31:0] gv, sv, dv;
    gv = g; sv = src; dv = dst;
    return {gv[2:0], sv[5:0], imm, dv[5:0]};
  endfunction
  function automatic logic [63:0] bnd(input logic [15:0] m0, m1, m2, m3);
    return {m3, m2, m1, m0};
  endfunction
  localparam logic [15:0] NOP = 16'h2000; // guard 1

  task automatic check(input string req, input logic [15:0] actual, input logic [15:0] expected);
    checkCnt++;
    if (actual !== expected) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic checkReg(input string req, input int idx, input logic [15:0] expected);
    dbgSel = 4'(idx);
    #1;
    check(req, dbgData, expected);
  endtask

  task automatic clearProg();
    for (int i = 0; i < 16; i++) prog[i] = bnd(NOP, NOP, NOP, NOP);
  endtask

  // Load the program while reset is held, then release
  task automatic loadAndRun(input int runCycles);
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < 16; i++) begin
      loadWe = 1'b1; loadAddr = 6'(i); loadData = prog[i];
      @(negedge clk);
    end
    loadWe = 1'b0;
    rstN = 1'b1;
    repeat (runCycles) @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 pc in reset", 16'(pcOut), 16'h0);
    check("R9 flags in reset", 16'(flagsOut), 16'h0);
    for (int i = 0; i < 11; i++) checkReg("R9 register in reset", i, 16'h0);
  endtask

  task automatic testMoves();
    clearProg();
    prog[0] = bnd(mv(0, 5, 1, 1), mv(0, -3, 1, 2), mv(0, 31, 1, 3), NOP);
    prog[1] = bnd(mv(0, 1, 0, 4), mv(0, 2, 0, 1), mv(0, 1, 0, 2), mv(0, 7, 1, 0));
    prog[2] = bnd(mv(0, 0, 0, 5), NOP, NOP, NOP);
    prog[3] = bnd(mv(0, 3, 1, 24), NOP, NOP, NOP);
    loadAndRun(3);
    check("R10 sequential fetch", 16'(pcOut), 16'h2);
    repeat (20) @(negedge clk);
    checkReg("R8 swap r1", 1, 16'hFFFD);
    checkReg("R8 swap r2", 2, 16'h0005);
    checkReg("R1 positive immediate", 3, 16'h001F);
    checkReg("R8 copy reads old r1", 4, 16'h0005);
    checkReg("R5 r0 ignores write", 5, 16'h0000);
    checkReg("R5 r0 reads zero", 0, 16'h0000);
    check("R6 halt pc", 16'(pcOut), 16'h3);
  endtask

  task automatic testAdd();
    clearProg();
    prog[0] = bnd(mv(0, 20, 1, 1), mv(0, 22, 1, 2), NOP, NOP);
    prog[1] = bnd(mv(0, 1, 0, 16), mv(0, 2, 0, 17), NOP, NOP);
    prog[2] = bnd(mv(0, 16, 0, 3), mv(0, -5, 1, 16), mv(0, 1, 1, 17), NOP);
    prog[3] = bnd(mv(0, 16, 0, 4), NOP, NOP, NOP);
    prog[4] = bnd(mv(1, 9, 1, 6), mv(0, 9, 1, 7), mv(0, 4, 1, 24), NOP);
    loadAndRun(25);
    checkReg("R4 add with same-bundle operand", 3, 16'd42);
    checkReg("R4 add negative", 4, 16'hFFFC);
    checkReg("R2 never guard", 6, 16'h0000);
    checkReg("R2 always guard", 7, 16'h0009);
    check("R6 halt pc", 16'(pcOut), 16'h4);
  endtask

  task automatic testGuards();
    clearProg();
    prog[0] = bnd(mv(0, 5, 1, 18), mv(0, 5, 1, 19), mv(0, 3, 1, 20), mv(0, -1, 1, 21));
    prog[1] = bnd(mv(2, 1, 1, 1), mv(3, 1, 1, 2), mv(5, 1, 1, 3), mv(6, 1, 1, 4));
    prog[2] = bnd(mv(4, 1, 1, 5), mv(7, 1, 1, 6), mv(0, 11, 1, 7), mv(0, 22, 1, 7));
    prog[3] = bnd(mv(0, 0, 1, 19), mv(2, 3, 1, 8), mv(0, 4, 1, 24), mv(0, 6, 1, 24));
    prog[4] = bnd(mv(0, 1, 1, 9), NOP, NOP, NOP);
    prog[5] = bnd(mv(0, 2, 1, 9), NOP, NOP, NOP);
    prog[6] = bnd(mv(0, 7, 1, 10), mv(0, 6, 1, 24), NOP, NOP);
    loadAndRun(25);
    checkReg("R3 f0 true taken", 1, 16'h1);
    checkReg("R3 inverse f0 skipped", 2, 16'h0);
    checkReg("R3 inverse f1 signed taken", 3, 16'h1);
    checkReg("R3 f2 unsigned taken", 4, 16'h1);
    checkReg("R3 f1 false skipped", 5, 16'h0);
    checkReg("R3 inverse f2 skipped", 6, 16'h0);
    checkReg("R7 higher slot wins", 7, 16'd22);
    checkReg("R3 guard uses pre-bundle flag", 8, 16'h3);
    checkReg("R7 pc conflict skips bundles", 9, 16'h0);
    checkReg("R6 jump target executed", 10, 16'h7);
    check("R3 final flags", 16'(flagsOut), 16'h4);
    check("R6 halt pc", 16'(pcOut), 16'h6);
  endtask

  task automatic testLoop();
    clearProg();
    prog[0] = bnd(mv(0, 0, 1, 1), NOP, NOP, NOP);
    prog[1] = bnd(mv(0, 1, 0, 16), mv(0, 1, 1, 17), NOP, NOP);
    prog[2] = bnd(mv(0, 16, 0, 1), mv(0, 16, 0, 18), mv(0, 5, 1, 19), mv(0, 17, 0, 3));
    prog[3] = bnd(mv(3, 1, 1, 24), NOP, NOP, NOP);
    prog[4] = bnd(mv(0, 9, 1, 5), mv(0, 4, 1, 24), NOP, NOP);
    loadAndRun(40);
    checkReg("R3 loop count", 1, 16'd5);
    checkReg("R6 link address", 3, 16'd3);
    checkReg("R10 fall-through after loop", 5, 16'd9);
    check("R6 loop halt pc", 16'(pcOut), 16'h4);
  endtask

  initial begin
    #2_000_000;
    failCnt++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    testReset();
    testMoves();
    testAdd();
    testGuards();
    testLoop();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule